// File: doc/BRIEF.md
# Multi-Mode Serial Shift Transfer Controller

This block moves one byte at a time over a synchronous serial link. The processor writes a byte into the shift register, and that write is also the start command. The internally generated serial clock then runs for eight periods. Each period drives one bit out and samples one bit in. When the last period ends, the clock returns high, the transfer-active bit drops, and the interrupt request flag is raised. A later read of the shift register returns the byte that was received.

Three pin behaviours are selected by `mode`:

- **Three-wire (`2'b00`).** Push-pull data output on `sd_out`. The reserved code `2'b11` behaves the same way.
- **Two-wire (`2'b01`).** Open-drain output. `sd_pull_low` asserts only for a 0 bit.
- **Serial bus (`2'b10`).** Open-drain output, with two additions. A start is held while the slave signals busy. A wake-up bit keeps the pull-down released.

A write is accepted only when the enable input is 1 and no transfer is running. Raising the enable afterwards never starts a transfer on its own.

Top module: `sio_shift_ctrl`

## Requirements
- R1: A write (`wr_en`=1) with `enable`=1, while no transfer is active, starts a transfer at that clock edge. `xfer_active` reads 1 from the next cycle and `sck_out` goes low at the same edge. In serial-bus mode this also requires `slave_busy`=0 and `sd_in`=1.
- R2: A write made while a transfer is active is ignored. The transmitted byte, the received byte and the transfer length are all unchanged.
- R3: A write with `enable`=0 loads the register, so it is visible on `rd_data`, but starts nothing. Setting `enable` to 1 afterwards does not start a transfer.
- R4: A transfer lasts exactly 8 serial clock periods, which is 16*HALF_CYC system cycles. Afterwards `xfer_active` is 0 and `sck_out` is 1.
- R5: `irq` is set when a transfer ends and stays set until an `irq_clr` pulse. A new transfer start does not clear it. If the end of a transfer and the clear arrive in the same cycle, the set wins.
- R6: Data leaves MSB first. The output bit changes only on falling edges of `sck_out`. `sd_in` is sampled on rising edges into the register LSB.
- R7: Between transfers, `rd_data` returns the eight bits received in the most recent completed transfer.
- R8: In three-wire mode, `sd_pull_low` is never asserted and the bits appear on `sd_out`.
- R9: In two-wire mode, `sd_pull_low` is 1 exactly while the current output bit is 0. A byte of 0xFF therefore never pulls the line, which is the pure-receive case.
- R10: In serial-bus mode with `wake`=1, `sd_pull_low` stays 0 whatever the register holds.
- R11: In serial-bus mode, a write made while `slave_busy`=1 is kept pending. The transfer starts at the first edge where `slave_busy`=0 and `sd_in`=1.
- R12: After reset, these outputs are all 0: `irq`, `xfer_active`, `rd_data` and `sd_pull_low`. `sck_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Shift-register write strobe (start request) |
| wr_data | input | DATA_W | Byte to transmit |
| rd_data | output | DATA_W | Shift-register contents |
| enable | input | 1 | Interface enable |
| mode | input | 2 | 00 three-wire, 01 two-wire, 10 serial bus, 11 as 00 |
| wake | input | 1 | Wake-up bit, releases pull-down in bus mode |
| irq_clr | input | 1 | Interrupt flag clear strobe |
| irq | output | 1 | Transfer-complete interrupt request |
| xfer_active | output | 1 | Transfer in progress (read-only status) |
| sck_out | output | 1 | Serial clock, idles high |
| sd_out | output | 1 | Push-pull serial data out |
| sd_pull_low | output | 1 | Open-drain pull-down enable |
| sd_in | input | 1 | Serial data line in |
| slave_busy | input | 1 | Slave busy indication (bus mode) |

## Verification
The assertions hold on every cycle for the following properties:

- No start is issued while disabled, while active, or while the slave is busy in bus mode.
- The output bit holds between falling clock edges.
- The bit sampled on a rising edge lands in the LSB.
- The interrupt flag sets, holds and clears as specified.
- The pull-down stays released in three-wire mode and in bus mode with wake-up set.

Only the bench scenarios can show the end-to-end behaviour:

- The exact transfer length.
- The full transmitted and received bytes under each mode.
- Enable raised after a write leaving the block idle.
- A mid-transfer write being lost.
- A pending bus-mode write surviving busy and a low line, then starting.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [1:0] {
        MODE_3W  = 2'b00,
        MODE_2W  = 2'b01,
        MODE_BUS = 2'b10,
        MODE_RSV = 2'b11
    } sio_mode_e;

    typedef struct packed {
        logic rise;
        logic fall_slot;
    } sck_evt_t;

    function automatic logic mode_open_drain(sio_mode_e m);
        return (m == MODE_2W) || (m == MODE_BUS);
    endfunction

    function automatic logic pull_request(sio_mode_e m, logic bit_v, logic wake);
        logic released;
        released = (m == MODE_BUS) && wake;
        return mode_open_drain(m) && !bit_v && !released;
    endfunction

endpackage

// File: rtl/sio_sck_gen.sv
module sio_sck_gen #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    input  logic halt,
    output logic sck,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck <= 1'b1;
        end else if (start) begin
            sck <= 1'b0;
        end else if (halt) begin
            sck <= 1'b1;
        end else if (tick) begin
            sck <= ~sck;
        end
    end

    // R4: the clock rests high whenever no transfer runs
    assert_sck_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !run |-> sck)
        else $error("sck low while idle");

endmodule

// File: rtl/sio_start_ctrl.sv
module sio_start_ctrl
    import sio_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      enable,
    input  sio_mode_e mode,
    input  logic      slave_busy,
    input  logic      line_in,
    input  logic      active,
    output logic      start
);
    logic bus_mode;
    logic gate_ok;
    logic direct;
    logic release_go;
    logic pending;

    assign bus_mode   = (mode == MODE_BUS);
    assign gate_ok    = !bus_mode || (!slave_busy && line_in);
    assign direct     = wr_en && enable && !active && gate_ok;
    assign release_go = pending && enable && bus_mode && !slave_busy && line_in && !active;
    assign start      = direct || release_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (start) begin
            pending <= 1'b0;
        end else if (wr_en && enable && !active && !gate_ok) begin
            pending <= 1'b1;
        end else if (!enable || !bus_mode) begin
            pending <= 1'b0;
        end
    end

    assert_no_start_disabled_R3: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !start)
        else $error("start while disabled");

    assert_busy_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_mode && slave_busy) |-> !start)
        else $error("start while slave busy");

    assert_no_restart_R2: assert property (@(posedge clk) disable iff (rst)
        active |-> !start)
        else $error("start during active transfer");

endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
    import sio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              load,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sd_in,
    input  logic              tick,
    input  logic              sck,
    output logic              active,
    output logic [DATA_W-1:0] shreg,
    output logic              out_bit,
    output logic              done
);
    localparam int BW = $clog2(DATA_W + 1);
    localparam logic [BW-1:0] FULL = BW'(DATA_W);

    logic [BW-1:0] bits;
    sck_evt_t      evt;

    assign evt.rise      = tick && !sck;
    assign evt.fall_slot = tick && sck;
    assign done          = evt.fall_slot && (bits == FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            bits    <= '0;
            shreg   <= '0;
            out_bit <= 1'b1;
        end else if (start) begin
            active  <= 1'b1;
            bits    <= '0;
            out_bit <= load ? wr_data[DATA_W-1] : shreg[DATA_W-1];
            if (load) begin
                shreg <= wr_data;
            end
        end else if (load) begin
            shreg <= wr_data;
        end else if (evt.rise) begin
            shreg <= {shreg[DATA_W-2:0], sd_in};
            bits  <= bits + 1'b1;
        end else if (evt.fall_slot) begin
            if (bits == FULL) begin
                active  <= 1'b0;
                out_bit <= 1'b1;
            end else begin
                out_bit <= shreg[DATA_W-1];
            end
        end
    end

    assert_bits_bound_R4: assert property (@(posedge clk) disable iff (rst)
        bits <= FULL)
        else $error("bit count overrun");

    assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (active && !evt.fall_slot) |=> $stable(out_bit))
        else $error("output changed off a falling edge");

    assert_shift_in_R6: assert property (@(posedge clk) disable iff (rst)
        evt.rise |=> (shreg[0] == $past(sd_in)))
        else $error("sampled bit not in LSB");

endmodule

// File: rtl/sio_shift_ctrl.sv
module sio_shift_ctrl
    import sio_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HALF_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              enable,
    input  logic [1:0]        mode,
    input  logic              wake,
    input  logic              irq_clr,
    output logic              irq,
    output logic              xfer_active,
    output logic              sck_out,
    output logic              sd_out,
    output logic              sd_pull_low,
    input  logic              sd_in,
    input  logic              slave_busy
);
    sio_mode_e mode_q;
    logic      start;
    logic      active;
    logic      tick;
    logic      sck;
    logic      done;
    logic      out_bit;
    logic      load;

    assign mode_q = sio_mode_e'(mode);
    assign load   = wr_en && !active;

    sio_start_ctrl u_start (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .enable     (enable),
        .mode       (mode_q),
        .slave_busy (slave_busy),
        .line_in    (sd_in),
        .active     (active),
        .start      (start)
    );

    sio_sck_gen #(.HALF_CYC(HALF_CYC)) u_sck (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .run   (active),
        .halt  (done),
        .sck   (sck),
        .tick  (tick)
    );

    sio_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .load    (load),
        .wr_data (wr_data),
        .sd_in   (sd_in),
        .tick    (tick),
        .sck     (sck),
        .active  (active),
        .shreg   (rd_data),
        .out_bit (out_bit),
        .done    (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (done) begin
            irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end

    assign xfer_active = active;
    assign sck_out     = sck;
    assign sd_out      = out_bit;
    assign sd_pull_low = pull_request(mode_q, out_bit, wake);

    assert_irq_set_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> irq)
        else $error("irq not raised at end");

    assert_irq_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq)
        else $error("irq dropped without clear");

    assert_irq_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !done) |=> !irq)
        else $error("irq not cleared");

    assert_wake_release_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_BUS && wake) |-> !sd_pull_low)
        else $error("pull-down active under wake-up");

    assert_push_pull_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_3W) |-> !sd_pull_low)
        else $error("pull-down active in three-wire mode");

endmodule

// File: tb/sio_shift_ctrl_bench.sv
module sio_shift_ctrl_bench;
    localparam int HALF = 4;
    localparam int XFER = 16 * HALF;
    localparam int NV   = 8;
    // {mode[1:0], wake, tx[7:0], rx[7:0]}
    localparam logic [18:0] VEC [NV] = '{
        {2'b00, 1'b0, 8'hA5, 8'h3C},
        {2'b00, 1'b0, 8'h01, 8'h80},
        {2'b01, 1'b0, 8'h5A, 8'hC3},
        {2'b01, 1'b0, 8'hFF, 8'h96},
        {2'b10, 1'b0, 8'hE7, 8'h18},
        {2'b10, 1'b1, 8'h00, 8'h6D},
        {2'b00, 1'b1, 8'hFF, 8'h00},
        {2'b10, 1'b0, 8'h80, 8'h01}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       enable = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       wake = 1'b0;
    logic       irq_clr = 1'b0;
    logic       irq;
    logic       xfer_active;
    logic       sck_out;
    logic       sd_out;
    logic       sd_pull_low;
    logic       sd_in = 1'b1;
    logic       slave_busy = 1'b0;

    int         nchk = 0;
    int         nfail = 0;
    int         pull_viol = 0;
    logic [7:0] rx_sh = 8'h00;
    logic [7:0] tx_cap = 8'h00;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    sio_shift_ctrl #(.DATA_W(8), .HALF_CYC(HALF)) u_sio_shift_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .enable(enable), .mode(mode), .wake(wake), .irq_clr(irq_clr), .irq(irq),
        .xfer_active(xfer_active), .sck_out(sck_out), .sd_out(sd_out),
        .sd_pull_low(sd_pull_low), .sd_in(sd_in), .slave_busy(slave_busy)
    );

    // Peer model: present next receive bit on every falling clock edge
    always @(negedge sck_out) begin
        sd_in = rx_sh[7];
        rx_sh = {rx_sh[6:0], 1'b0};
    end

    // Capture the transmitted bit on every rising clock edge
    always @(posedge sck_out) begin
        tx_cap = {tx_cap[6:0], (mode == 2'b01 || mode == 2'b10) ? !sd_pull_low : sd_out};
    end

    // R8: three-wire mode must never pull the line
    always @(negedge clk) begin
        if (!rst && (mode == 2'b00) && sd_pull_low) pull_viol++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 1;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (!xfer_active) break;
            cyc++;
        end
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic run_vec(input logic [1:0] m, input logic w, input logic [7:0] tx,
                           input logic [7:0] rx, input bit mid_wr, input bit clr);
        int   cyc;
        logic irq_pre;
        mode = m; wake = w; sd_in = 1'b1; rx_sh = rx; tx_cap = 8'h00;
        irq_pre = irq;
        wr_en = 1'b1; wr_data = tx;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R1 active after write", 32'(xfer_active), 32'd1);
        chk("R5 start keeps irq", 32'(irq), 32'(irq_pre));
        cyc = 1;
        for (int k = 0; k < 2000; k++) begin
            if (mid_wr && cyc == 10) begin wr_en = 1'b1; wr_data = 8'h00; end
            if (mid_wr && cyc == 11) wr_en = 1'b0;
            @(negedge clk);
            if (!xfer_active) break;
            cyc++;
        end
        wr_en = 1'b0;
        chk("R4 transfer length", 32'(cyc), 32'(XFER));
        chk("R4 clock high after", 32'(sck_out), 32'd1);
        chk("R5 irq at end", 32'(irq), 32'd1);
        chk("R7 received byte", 32'(rd_data), 32'(rx));
        chk("R6 R9 R10 transmitted byte", 32'(tx_cap),
            (m == 2'b10 && w) ? 32'hFF : 32'(tx));
        sd_in = 1'b1;
        if (clr) pulse_clr();
    endtask

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 irq", 32'(irq), 32'd0);
        chk("R12 active", 32'(xfer_active), 32'd0);
        chk("R12 sck", 32'(sck_out), 32'd1);
        chk("R12 rd_data", 32'(rd_data), 32'd0);
        chk("R12 pull", 32'(sd_pull_low), 32'd0);

        // R3: write while disabled, then enable
        wr_en = 1'b1; wr_data = 8'h77;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 no start when disabled", 32'(xfer_active), 32'd0);
        chk("R3 register loaded", 32'(rd_data), 32'h77);
        enable = 1'b1;
        repeat (10) @(negedge clk);
        chk("R3 enable alone no start", 32'(xfer_active), 32'd0);
        chk("R3 clock idle", 32'(sck_out), 32'd1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i][18:17], VEC[i][16], VEC[i][15:8], VEC[i][7:0], 1'b0, 1'b1);
        end
        chk("R8 no pull in three-wire", 32'(pull_viol), 32'd0);

        // R2: write during transfer ignored; keep irq for R5
        run_vec(2'b00, 1'b0, 8'hC6, 8'h29, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        chk("R5 irq sticky", 32'(irq), 32'd1);
        run_vec(2'b01, 1'b0, 8'h3B, 8'hD4, 1'b0, 1'b0);
        pulse_clr();
        chk("R5 irq cleared", 32'(irq), 32'd0);

        // R11: bus mode, busy slave holds the start
        mode = 2'b10; wake = 1'b0; slave_busy = 1'b1; sd_in = 1'b1;
        wr_en = 1'b1; wr_data = 8'h3A;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (6) @(negedge clk);
        chk("R11 held while busy", 32'(xfer_active), 32'd0);
        chk("R11 write kept", 32'(rd_data), 32'h3A);
        sd_in = 1'b0; slave_busy = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 held while line low", 32'(xfer_active), 32'd0);
        rx_sh = 8'hB1; tx_cap = 8'h00;
        sd_in = 1'b1;
        @(negedge clk);
        chk("R11 starts on release", 32'(xfer_active), 32'd1);
        wait_idle(cyc);
        chk("R11 length", 32'(cyc), 32'(XFER));
        chk("R11 received", 32'(rd_data), 32'hB1);
        chk("R11 transmitted", 32'(tx_cap), 32'h3A);
        sd_in = 1'b1;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule